// File: doc/BRIEF.md
# Chip-Select Activity Watchdog

This block watches a serial chip-select line and treats any change of its level, rising or falling, as a sign that the host is still alive. Each such change restarts an internal cycle counter. If the counter runs a full time-out period with no change, the block raises a time-out request: a single-cycle strobe and a level that stays high for a recovery hold. The reset generator uses these to drive its complementary reset outputs, and counting then resumes from zero.

The counter is kept cleared whenever the system is not in a state where a time-out makes sense. While the supply-good status is low, it stays cleared. Once the supply is good, it waits for a power-on hold period before it starts. Either external reset input (one active-high, one active-low) also holds it cleared. That hold ends only when both the hold period has run and the input has been released. The chip-select line is asynchronous and passes through a two-stage synchronizer before edge detection. The supply-good and external reset inputs are synchronous to the block clock.

The time-out length (`TIMEOUT_CYCLES`, default 1.6 s at 250 MHz) and the hold length (`HOLD_CYCLES`, default 150 ms) are parameters in clock cycles.

Top module: `selWatchdog`

## Requirements
- R1: While `rstN` is low and right after it rises, `timeoutPulse` and `timeoutLevel` are 0 and the block waits for supply-good.
- R2: While `supplyGood` is sampled low, no time-out occurs, however long the line stays idle.
- R3: If `supplyGood` is first sampled high at clock edge a and the line stays idle, `timeoutPulse` is high right after edge a+HOLD_CYCLES+1+TIMEOUT_CYCLES.
- R4: A change of `chipSel` in either direction, first sampled at edge s, restarts the count. With no further change, the next time-out pulse follows edge s+2+TIMEOUT_CYCLES.
- R5: If a restart and the time-out fall in the same cycle, the restart wins and no pulse is produced. A change sampled at edge r+TIMEOUT_CYCLES-2 after counting began at edge r still prevents the time-out. A change sampled one edge later does not.
- R6: A time-out gives `timeoutPulse` high for exactly one cycle. `timeoutLevel` rises in that same cycle and stays high for HOLD_CYCLES+1 cycles. After that the count restarts from zero, so the next pulse comes HOLD_CYCLES+1+TIMEOUT_CYCLES edges after the previous one.
- R7: While an external reset input is asserted, no time-out occurs and the counter is held. If the assertion is first sampled at edge e and the release at edge x, counting restarts at edge max(e+HOLD_CYCLES+1, x).
- R8: The external reset is asserted by `extResetHigh` = 1 or `extResetLowN` = 0, and either one alone has the full effect of R7.
- R9: An external reset sampled during the time-out level ends that level after the same edge and starts a new hold as in R7.
- R10: A new assertion of an external reset during a hold, after an earlier release, restarts the hold period from that assertion.
- R11: Supply-good going low at any time clears `timeoutLevel` after the next edge and returns the block to the wait of R3.
- R12: Changes of `chipSel` while the counter is held have no effect on when counting starts or when the next time-out follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Serial chip-select line, asynchronous; any change restarts the count |
| supplyGood | input | 1 | Supply above trip level, synchronous |
| extResetHigh | input | 1 | External reset request, active high, synchronous |
| extResetLowN | input | 1 | External reset request, active low, synchronous |
| timeoutPulse | output | 1 | One-cycle strobe on time-out |
| timeoutLevel | output | 1 | High during the recovery hold that follows a time-out |

## Verification
A restart from the chip-select line and the expiry of the count can fall in the same cycle. So can an external reset and that expiry. The bench provokes the first collision by placing a chip-select change so that its synchronized edge lands exactly on the expiry cycle, and one edge later. It expects the pulse to vanish in the first case and appear on time in the second. External resets are applied exactly as the time-out level rises, and at random during a long run. A cycle model of the requirements judges every cycle of these runs, and measured pulse distances are checked against the R3–R10 formulas.

// File: rtl/selWdogPkg.sv
package selWdogPkg;

  typedef enum logic [1:0] {
    ST_POWER_WAIT = 2'd0,
    ST_HOLD       = 2'd1,
    ST_RUN        = 2'd2,
    ST_EXPIRED    = 2'd3
  } wdState_t;

  typedef struct packed {
    logic wdClr;
    logic wdInc;
    logic holdClr;
    logic holdInc;
    logic expire;
  } wdStrobe_t;

endpackage

// File: rtl/selWdogActivity.sv
module selWdogActivity #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic extResetHigh,
  input  logic extResetLowN,
  output logic kick,
  output logic extActive,
  output logic extRise
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic lastSeen;
  logic extPrev;

  // two or more flops before the select line is trusted
  generate
    if (SYNC_STAGES < 2) begin : gBadDepth
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      lastSeen  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], chipSel};
      lastSeen  <= syncChain[LAST_STAGE];
    end
  end

  // either direction of the synchronized line counts as activity
  assign kick = syncChain[LAST_STAGE] ^ lastSeen;

  assign extActive = extResetHigh | ~extResetLowN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extActive;
  end

  assign extRise = extActive & ~extPrev;

endmodule

// File: rtl/selWdogDatapath.sv
module selWdogDatapath
  import selWdogPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 400_000_000,
  parameter int HOLD_CYCLES    = 37_500_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  wdStrobe_t strobe,
  output logic      wdLast,
  output logic      holdDone,
  output logic      expirePulse
);

  localparam int WD_W   = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [WD_W-1:0]   WD_END   = WD_W'(TIMEOUT_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(HOLD_CYCLES);

  logic [WD_W-1:0]   wdCount;
  logic [HOLD_W-1:0] holdCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wdCount <= '0;
    else if (strobe.wdClr) wdCount <= '0;
    else if (strobe.wdInc) wdCount <= wdCount + WD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCount <= '0;
    else if (strobe.holdClr) holdCount <= '0;
    else if (strobe.holdInc) holdCount <= holdCount + HOLD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) expirePulse <= 1'b0;
    else       expirePulse <= strobe.expire;
  end

  assign wdLast   = (wdCount == WD_END);
  assign holdDone = (holdCount == HOLD_END);

endmodule

// File: rtl/selWdogCtrl.sv
module selWdogCtrl
  import selWdogPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyGood,
  input  logic      kick,
  input  logic      extActive,
  input  logic      extRise,
  input  logic      wdLast,
  input  logic      holdDone,
  output wdStrobe_t strobe,
  output logic      expiredLevel
);

  wdState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_POWER_WAIT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (!supplyGood) begin
      stateNext      = ST_POWER_WAIT;
      strobe.wdClr   = 1'b1;
      strobe.holdClr = 1'b1;
    end else begin
      unique case (state)
        ST_POWER_WAIT: begin
          stateNext      = ST_HOLD;
          strobe.wdClr   = 1'b1;
          strobe.holdClr = 1'b1;
        end
        ST_HOLD: begin
          strobe.wdClr = 1'b1;
          if (extRise)                     strobe.holdClr = 1'b1;
          else if (holdDone && !extActive) stateNext      = ST_RUN;
          else if (!holdDone)              strobe.holdInc = 1'b1;
        end
        ST_RUN: begin
          if (extActive) begin
            stateNext      = ST_HOLD;
            strobe.wdClr   = 1'b1;
            strobe.holdClr = 1'b1;
          end else if (kick) begin
            strobe.wdClr = 1'b1;
          end else if (wdLast) begin
            stateNext      = ST_EXPIRED;
            strobe.wdClr   = 1'b1;
            strobe.holdClr = 1'b1;
            strobe.expire  = 1'b1;
          end else begin
            strobe.wdInc = 1'b1;
          end
        end
        ST_EXPIRED: begin
          strobe.wdClr = 1'b1;
          if (extActive) begin
            stateNext      = ST_HOLD;
            strobe.holdClr = 1'b1;
          end else if (holdDone) begin
            stateNext = ST_RUN;
          end else begin
            strobe.holdInc = 1'b1;
          end
        end
        default: stateNext = ST_POWER_WAIT;
      endcase
    end
  end

  assign expiredLevel = (state == ST_EXPIRED);

endmodule

// File: rtl/selWatchdog.sv
module selWatchdog
  import selWdogPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 400_000_000,
  parameter int HOLD_CYCLES    = 37_500_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic supplyGood,
  input  logic extResetHigh,
  input  logic extResetLowN,
  output logic timeoutPulse,
  output logic timeoutLevel
);

  wdStrobe_t strobe;
  logic kick, extActive, extRise, wdLast, holdDone;

  selWdogActivity #(.SYNC_STAGES(SYNC_STAGES)) iActivity (
    .clk(clk), .rstN(rstN), .chipSel(chipSel),
    .extResetHigh(extResetHigh), .extResetLowN(extResetLowN),
    .kick(kick), .extActive(extActive), .extRise(extRise)
  );

  selWdogCtrl iCtrl (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .kick(kick),
    .extActive(extActive), .extRise(extRise), .wdLast(wdLast),
    .holdDone(holdDone), .strobe(strobe), .expiredLevel(timeoutLevel)
  );

  selWdogDatapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)
  ) iDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdLast(wdLast),
    .holdDone(holdDone), .expirePulse(timeoutPulse)
  );

endmodule

// File: rtl/selWatchdogChecker.sv
module selWatchdogChecker (
  input logic clk,
  input logic rstN,
  input logic chipSel,
  input logic supplyGood,
  input logic extResetHigh,
  input logic extResetLowN,
  input logic timeoutPulse,
  input logic timeoutLevel
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse); // R6

  AST_PULSE_IN_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> timeoutLevel); // R6

  AST_LEVEL_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutLevel) |-> timeoutPulse); // R6

  AST_SUPPLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> (!timeoutLevel && !timeoutPulse)); // R11

  AST_EXT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (extResetHigh || !extResetLowN) |=> (!timeoutLevel && !timeoutPulse)); // R7

  AST_NO_EARLY_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyGood) |=> !timeoutPulse); // R3

endmodule

bind selWatchdog selWatchdogChecker iChecker (.*);

// File: tb/test_selWatchdog.sv
`timescale 1ns/1ps
module test_selWatchdog;

  localparam int TMO  = 40;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0;
  logic supplyGood = 1'b0;
  logic extResetHigh = 1'b0;
  logic extResetLowN = 1'b1;
  logic timeoutPulse, timeoutLevel;

  int testCount = 0;
  int failCount = 0;
  int cyc = 0;
  string phaseTag = "R1";

  // requirement-level model state
  int mState = 0;
  int mHold = 0;
  int mWd = 0;
  logic mSync0 = 0, mSync1 = 0, mLast = 0, mExtPrev = 0, mPulse = 0;

  always #2 clk = ~clk;

  selWatchdog #(.TIMEOUT_CYCLES(TMO), .HOLD_CYCLES(HOLD)) i_selWatchdog (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .supplyGood(supplyGood),
    .extResetHigh(extResetHigh), .extResetLowN(extResetLowN),
    .timeoutPulse(timeoutPulse), .timeoutLevel(timeoutLevel)
  );

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int expectAfterKick(int s);
    return s + 2 + TMO;
  endfunction

  task automatic checkEq(string tag, int actual, int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, actual, expected, cyc);
    end
  endtask

  task automatic modelStep();
    logic kickM, extA, extR, done, last;
    int ns, nHold, nWd;
    logic nPulse;
    if (!rstN) begin
      mState = 0; mHold = 0; mWd = 0; mSync0 = 0; mSync1 = 0;
      mLast = 0; mExtPrev = 0; mPulse = 0;
      return;
    end
    kickM = mSync1 ^ mLast;
    extA  = extResetHigh | ~extResetLowN;
    extR  = extA & ~mExtPrev;
    done  = (mHold == HOLD);
    last  = (mWd == TMO - 1);
    ns = mState; nHold = mHold; nWd = mWd; nPulse = 0;
    if (!supplyGood) begin
      ns = 0; nHold = 0; nWd = 0;
    end else begin
      case (mState)
        0: begin ns = 1; nHold = 0; nWd = 0; end
        1: begin
          nWd = 0;
          if (extR) nHold = 0;
          else if (done && !extA) ns = 2;
          else if (!done) nHold = mHold + 1;
        end
        2: begin
          if (extA) begin ns = 1; nHold = 0; nWd = 0; end
          else if (kickM) nWd = 0;
          else if (last) begin ns = 3; nHold = 0; nWd = 0; nPulse = 1; end
          else nWd = mWd + 1;
        end
        default: begin
          nWd = 0;
          if (extA) begin ns = 1; nHold = 0; end
          else if (done) ns = 2;
          else nHold = mHold + 1;
        end
      endcase
    end
    mLast = mSync1; mSync1 = mSync0; mSync0 = chipSel; mExtPrev = extA;
    mState = ns; mHold = nHold; mWd = nWd; mPulse = nPulse;
  endtask

  task automatic stepCycle();
    @(posedge clk);
    cyc++;
    modelStep();
    #1;
    checkEq({phaseTag, " pulse vs model"}, int'(timeoutPulse), int'(mPulse));
    checkEq({phaseTag, " level vs model"}, int'(timeoutLevel), (mState == 3) ? 1 : 0);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) stepCycle();
  endtask

  task automatic runUntilPulse(int maxc, output int edgeIdx);
    edgeIdx = -1;
    for (int i = 0; i < maxc; i++) begin
      stepCycle();
      if (timeoutPulse) begin edgeIdx = cyc; return; end
    end
  endtask

  task automatic waitRun(output int r);
    while (timeoutLevel) stepCycle();
    r = cyc;
  endtask

  task automatic toggleCs(output int s);
    chipSel = ~chipSel;
    stepCycle();
    s = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int a, p, p2, r, s, e, x, lvl, cnt, q;
    void'($urandom(32'h5eed_1234));
    // R1 reset
    phaseTag = "R1";
    steps(3);
    checkEq("R1 pulse in reset", int'(timeoutPulse), 0);
    checkEq("R1 level in reset", int'(timeoutLevel), 0);
    rstN = 1'b1;
    stepCycle();
    checkEq("R1 pulse after reset", int'(timeoutPulse), 0);

    // R2 supply low for a long idle stretch
    phaseTag = "R2";
    cnt = 0;
    for (int i = 0; i < 4 * TMO; i++) begin stepCycle(); if (timeoutPulse) cnt++; end
    checkEq("R2 no expiry while supply low", cnt, 0);

    // R3 power-up hold then first expiry
    phaseTag = "R3";
    supplyGood = 1'b1;
    stepCycle(); a = cyc;
    runUntilPulse(4 * TMO, p);
    checkEq("R3 first expiry edge", p, a + HOLD + 1 + TMO);

    // R6 level length and restart
    phaseTag = "R6";
    lvl = 0;
    while (timeoutLevel) begin lvl++; stepCycle(); end
    checkEq("R6 level cycles", lvl, HOLD + 1);
    runUntilPulse(4 * TMO, p2);
    checkEq("R6 pulse spacing", p2 - p, HOLD + 1 + TMO);

    // R4 kicks, last one falling then rising
    phaseTag = "R4";
    for (int round = 0; round < 2; round++) begin
      waitRun(r);
      for (int k = 0; k < 6 + round; k++) begin
        steps(5 + ($urandom % 25));
        toggleCs(s);
      end
      runUntilPulse(4 * TMO, p);
      checkEq(round == 0 ? "R4 falling kick restart" : "R4 rising kick restart", p, expectAfterKick(s));
    end

    // R5 kick colliding with expiry, and one edge too late
    phaseTag = "R5";
    waitRun(r);
    steps(TMO - 3);
    toggleCs(s);
    checkEq("R5 kick edge placement", s, r + TMO - 2);
    runUntilPulse(4 * TMO, p);
    checkEq("R5 kick wins over expiry", p, r + 2 * TMO);
    waitRun(r);
    steps(TMO - 2);
    toggleCs(s);
    runUntilPulse(4 * TMO, p);
    checkEq("R5 late kick loses", p, r + TMO);

    // R7 long active-high external reset
    phaseTag = "R7";
    waitRun(r);
    steps(5);
    extResetHigh = 1'b1; stepCycle(); e = cyc;
    steps(29);
    checkEq("R7 level held low", int'(timeoutLevel), 0);
    extResetHigh = 1'b0; stepCycle(); x = cyc;
    runUntilPulse(4 * TMO, p);
    checkEq("R7 long assertion exit", p, maxOf(e + HOLD + 1, x) + TMO);

    // R8 short active-low external reset
    phaseTag = "R8";
    waitRun(r);
    steps(5);
    extResetLowN = 1'b0; stepCycle(); e = cyc;
    stepCycle();
    extResetLowN = 1'b1; stepCycle(); x = cyc;
    runUntilPulse(4 * TMO, p);
    checkEq("R8 active-low short assertion", p, maxOf(e + HOLD + 1, x) + TMO);

    // R9 external reset right at the time-out
    phaseTag = "R9";
    extResetHigh = 1'b1; stepCycle(); e = cyc;
    checkEq("R9 level cut by ext reset", int'(timeoutLevel), 0);
    steps(2);
    extResetHigh = 1'b0; stepCycle(); x = cyc;
    runUntilPulse(4 * TMO, p);
    checkEq("R9 restart after cut", p, maxOf(e + HOLD + 1, x) + TMO);

    // R10 re-assertion restarts hold
    phaseTag = "R10";
    waitRun(r);
    steps(5);
    extResetHigh = 1'b1; stepCycle(); e = cyc;
    steps(2);
    extResetHigh = 1'b0; stepCycle();
    steps(2);
    extResetHigh = 1'b1; stepCycle(); q = cyc;
    extResetHigh = 1'b0; stepCycle();
    runUntilPulse(4 * TMO, p);
    checkEq("R10 hold restarted", p, q + HOLD + 1 + TMO);

    // R11 supply loss during level and during run
    phaseTag = "R11";
    supplyGood = 1'b0; stepCycle();
    checkEq("R11 level cleared by supply loss", int'(timeoutLevel), 0);
    steps(5);
    supplyGood = 1'b1; stepCycle(); a = cyc;
    steps(HOLD + 10);
    supplyGood = 1'b0; stepCycle();
    steps(5);
    supplyGood = 1'b1; stepCycle(); a = cyc;

    // R12 select activity during the hold is ignored
    phaseTag = "R12";
    for (int k = 0; k < 3; k++) begin stepCycle(); toggleCs(s); end
    runUntilPulse(4 * TMO, p);
    checkEq("R12 hold timing unaffected", p, a + HOLD + 1 + TMO);

    // mixed random activity judged by the model
    phaseTag = "R4 R7 R8 R11 random";
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 100) < 3) chipSel = ~chipSel;
      if (($urandom % 200) < 2) extResetHigh = ~extResetHigh;
      if (($urandom % 200) < 2) extResetLowN = ~extResetLowN;
      if (($urandom % 1000) < 3) supplyGood = ~supplyGood;
      if ((i % 400) == 399) begin extResetHigh = 1'b0; extResetLowN = 1'b1; supplyGood = 1'b1; end
      stepCycle();
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule